// File: doc/BRIEF.md
# Paged Program Counter with Latch

This block holds the 13-bit instruction address of a small processor with an 8-bit data path and an 8192-word program space. Each instruction the decoder either lets the address advance by one or raises one control-flow strobe: an in-page jump, a call, a return, or a write of new data into the low address byte. Calls save the following address on an internal eight-entry return stack, and any return restores it.

The upper five address bits are never produced by arithmetic on the low byte. They come from a separate five-bit latch that software writes ahead of time. The whole latch is copied into the counter when the low byte is written, which makes computed jumps and table lookups possible. Only its two top bits are used when a jump or call gives an 11-bit target, so these two bits select one of four 2K-word pages. The low byte can be read back. The latch cannot be read through this block.

Top module: `paged_pc`

## Requirements
- R1: When `rst` is high at a clock edge, the counter, the high latch and the return stack all clear. A low-byte write that follows reset therefore gives an upper part of 0.
- R2: When `adv` is the only control strobe high, the counter becomes its old value plus one, modulo 8192. 0x1FFF advances to 0x0000.
- R3: `lo_rd` always shows bits 7:0 of the counter.
- R4: When `lo_wr` wins, the counter becomes {latch[4:0], wdata[7:0]}. The upper five bits are the latch value, whatever the old counter held.
- R5: `hi_wr` loads `wdata[4:0]` into the high latch at the clock edge and does not move the counter.
- R6: When `jmp` wins, the counter becomes {latch[4:3], imm[10:0]}. Latch bits 2:0 have no effect.
- R7: When `call` wins, the counter is loaded as for a jump and the old counter plus one (modulo 8192) is pushed onto the return stack.
- R8: When `ret` is high, the counter takes the most recently pushed address that has not yet been popped.
- R9: The stack holds 8 entries and wraps circularly. After nine calls, the ninth push has overwritten the first. Pops then return pushes 9, 8, ..., 2 and after that push 9 again. No error is signalled.
- R10: Priority, from highest to lowest: `ret`, `call`, `jmp`, `lo_wr`, `adv`. When no strobe is high, the counter holds its value.
- R11: Jumps, calls and returns leave the high latch unchanged. A later low-byte write shows this.
- R12: When `hi_wr` and `lo_wr` are high in the same cycle, the low-byte write uses the latch value from before that edge. The new value applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance to the next sequential address |
| jmp | input | 1 | In-page jump to `imm` |
| call | input | 1 | In-page call to `imm`, pushes the return address |
| ret | input | 1 | Return: pop the stack into the counter |
| lo_wr | input | 1 | Write `wdata` into the low byte and copy the latch into the upper bits |
| hi_wr | input | 1 | Load `wdata[4:0]` into the high latch |
| imm | input | 11 | Jump or call target within the page |
| wdata | input | 8 | Write data for the low byte and the latch |
| pc | output | 13 | Current program address |
| lo_rd | output | 8 | Readable low byte of the counter |

## Verification
The assertions assume that the strobes are already resolved to one event per cycle by the time they are checked. For this reason every property is gated by the same priority that the next-address mux uses, and only the winning strobe is checked. They also assume that no return is issued against an empty stack before a call. In that case the entry popped after reset is zero, and no property relies on anything else. The stimulus runs mostly single-strobe cycles. It combines strobes deliberately only to exercise the priority order and the same-cycle latch and low-byte write. Its call depth goes one past the stack size so that the wrap occurs, and each pop is then compared against a circular reference model.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
    parameter int PC_W      = 13;
    parameter int LO_W      = 8;
    parameter int IMM_W     = 11;
    localparam int HI_W     = PC_W - LO_W;
    localparam int PG_W     = PC_W - IMM_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [HI_W-1:0]  hi_t;
    typedef logic [LO_W-1:0]  lo_t;
    typedef logic [IMM_W-1:0] imm_t;

    typedef enum logic [2:0] {
        OP_HOLD, OP_ADV, OP_LOWR, OP_JUMP, OP_CALL, OP_RET
    } pc_op_e;

    typedef struct packed {
        logic ret;
        logic call;
        logic jmp;
        logic lo_wr;
        logic adv;
    } strobes_t;

    // Fixed priority: return, call, jump, low write, advance.
    function automatic pc_op_e pick_op(strobes_t s);
        if (s.ret)        return OP_RET;
        else if (s.call)  return OP_CALL;
        else if (s.jmp)   return OP_JUMP;
        else if (s.lo_wr) return OP_LOWR;
        else if (s.adv)   return OP_ADV;
        else              return OP_HOLD;
    endfunction

    function automatic pc_t page_target(hi_t lat, imm_t tgt);
        return {lat[HI_W-1 -: PG_W], tgt};
    endfunction
endpackage

// File: rtl/pgpc_stack.sv
module pgpc_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

    logic [W-1:0]    mem [DEPTH];
    logic [SP_W-1:0] sp;       // next free slot
    logic [SP_W-1:0] sp_inc;
    logic [SP_W-1:0] sp_dec;

    always_comb begin
        sp_inc = (sp == LAST) ? '0 : sp + SP_W'(1);
        sp_dec = (sp == '0) ? LAST : sp - SP_W'(1);
    end

    assign top = mem[sp_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (pop) begin
            sp <= sp_dec;
        end else if (push) begin
            sp <= sp_inc;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && !pop && sp == SP_W'(i))
                mem[i] <= din;
        end
    end

    // R9: a push into the last slot wraps the pointer to slot zero
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && sp == LAST) |=> sp == '0);
    // R8: a pushed value is what the next pop sees
    p_push_top_r8: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> top == $past(din));
endmodule

// File: rtl/pgpc_next.sv
module pgpc_next
    import pgpc_pkg::*;
(
    input  pc_op_e op,
    input  pc_t    cur,
    input  hi_t    lat,
    input  imm_t   imm,
    input  lo_t    wdata,
    input  pc_t    stk_top,
    output pc_t    nxt,
    output pc_t    ret_addr
);
    always_comb begin
        ret_addr = cur + PC_W'(1);
        unique case (op)
            OP_ADV:  nxt = ret_addr;
            OP_LOWR: nxt = {lat, wdata};
            OP_JUMP,
            OP_CALL: nxt = page_target(lat, imm);
            OP_RET:  nxt = stk_top;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import pgpc_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic                jmp,
    input  logic                call,
    input  logic                ret,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [IMM_W-1:0]    imm,
    input  logic [LO_W-1:0]     wdata,
    output logic [PC_W-1:0]     pc,
    output logic [LO_W-1:0]     lo_rd
);
    strobes_t stb;
    pc_op_e   op;
    pc_t      pc_q, pc_d, ret_addr, stk_top;
    hi_t      lat_q;

    assign stb = '{ret: ret, call: call, jmp: jmp, lo_wr: lo_wr, adv: adv};
    assign op  = pick_op(stb);

    pgpc_next u_next (
        .op(op), .cur(pc_q), .lat(lat_q), .imm(imm), .wdata(wdata),
        .stk_top(stk_top), .nxt(pc_d), .ret_addr(ret_addr)
    );

    pgpc_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push(op == OP_CALL), .pop(op == OP_RET),
        .din(ret_addr), .top(stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            lat_q <= '0;
        end else begin
            pc_q <= pc_d;
            if (hi_wr)
                lat_q <= wdata[HI_W-1:0];
        end
    end

    assign pc    = pc_q;
    assign lo_rd = pc_q[LO_W-1:0];

    // R10: no strobe, no movement
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(adv || jmp || call || ret || lo_wr) |=> $stable(pc));
    // R2: lone advance adds one
    p_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !(jmp || call || ret || lo_wr)) |=> pc == $past(pc) + PC_W'(1));
    // R4: winning low write places the data in the low byte
    p_lowr_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !(jmp || call || ret)) |=> lo_rd == $past(wdata));
    // R6: winning jump lands on the in-page target
    p_jump_r6: assert property (@(posedge clk) disable iff (rst)
        (jmp && !(call || ret)) |=> pc[IMM_W-1:0] == $past(imm));
    // R8: a return takes the stack top
    p_ret_r8: assert property (@(posedge clk) disable iff (rst)
        ret |=> pc == $past(stk_top));
    // R11: control flow leaves the latch alone
    p_latch_keep_r11: assert property (@(posedge clk) disable iff (rst)
        ((jmp || call || ret) && !hi_wr) |=> $stable(lat_q));
endmodule

// File: tb/paged_pc_tb.sv
module paged_pc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 0, jmp = 0, call = 0, ret = 0, lo_wr = 0, hi_wr = 0;
    logic [10:0] imm = '0;
    logic [7:0]  wdata = '0;
    logic [12:0] pc;
    logic [7:0]  lo_rd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [12:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // reference model
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #4 clk = ~clk;

    paged_pc u_dut (
        .clk(clk), .rst(rst), .adv(adv), .jmp(jmp), .call(call), .ret(ret),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .imm(imm), .wdata(wdata),
        .pc(pc), .lo_rd(lo_rd)
    );

    task automatic check(input logic [12:0] exp, input string tag);
        checks++;
        if (pc !== exp || lo_rd !== exp[7:0]) begin
            errors++;
            $display("FAIL %s: pc=%h lo_rd=%h expected pc=%h lo_rd=%h",
                     tag, pc, lo_rd, exp, exp[7:0]);
        end
    endtask

    // monitor: pop expected items and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.exp, it.tag);
        end
    end

    task automatic op(input bit a, input bit j, input bit c, input bit r,
                      input bit lw, input bit hw, input logic [10:0] im,
                      input logic [7:0] wd, input string tag);
        item_t it;
        @(negedge clk);
        adv = a; jmp = j; call = c; ret = r; lo_wr = lw; hi_wr = hw;
        imm = im; wdata = wd;
        // model, priority ret > call > jmp > lo_wr > adv
        if (r) begin
            m_sp = (m_sp + 7) % 8;
            m_pc = m_stk[m_sp];
        end else if (c) begin
            m_stk[m_sp] = m_pc + 13'd1;
            m_sp = (m_sp + 1) % 8;
            m_pc = {m_lat[4:3], im};
        end else if (j) begin
            m_pc = {m_lat[4:3], im};
        end else if (lw) begin
            m_pc = {m_lat, wd};
        end else if (a) begin
            m_pc = m_pc + 13'd1;
        end
        if (hw) m_lat = wd[4:0];
        @(posedge clk);
        #1;
        adv = 0; jmp = 0; call = 0; ret = 0; lo_wr = 0; hi_wr = 0;
        it.exp = m_pc;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(13'h0000, "R1 reset value");
        op(0,0,0,0,1,0, 11'h0, 8'h34, "R1 latch zero after reset");
        op(1,0,0,0,0,0, 11'h0, 8'h00, "R2 advance");
        op(1,0,0,0,0,0, 11'h0, 8'h00, "R2 advance again");
        op(0,0,0,0,0,0, 11'h0, 8'h00, "R10 hold");
        op(0,0,0,0,0,1, 11'h0, 8'hFF, "R5 latch write keeps pc");
        op(0,0,0,0,1,0, 11'h0, 8'hFF, "R4 low write with full latch");
        op(1,0,0,0,0,0, 11'h0, 8'h00, "R2 wrap to zero");
        op(0,0,0,0,0,1, 11'h0, 8'h05, "R5 latch write");
        op(0,0,0,0,1,0, 11'h0, 8'h00, "R4 upper bits from latch");
        op(0,0,0,0,0,1, 11'h0, 8'h1B, "R5 latch write 1B");
        op(0,1,0,0,0,0, 11'h123, 8'h00, "R6 jump uses latch[4:3] only");
        op(0,0,1,0,0,0, 11'h456, 8'h00, "R7 call target");
        op(0,0,0,1,0,0, 11'h000, 8'h00, "R8 return");
        op(0,0,0,0,1,0, 11'h0, 8'h00, "R11 latch kept across flow");
        op(0,0,0,0,1,1, 11'h0, 8'h04, "R12 same-cycle uses old latch");
        op(0,0,0,0,1,0, 11'h0, 8'h77, "R12 new latch next cycle");
        op(1,1,0,0,0,0, 11'h0AA, 8'h00, "R10 jump beats advance");
        op(1,0,0,0,1,0, 11'h0, 8'h5A, "R10 low write beats advance");
        op(0,0,1,1,0,0, 11'h222, 8'h00, "R10 return beats call");
        op(0,0,0,0,0,1, 11'h0, 8'h10, "R5 latch page 2");
        for (int k = 0; k < 9; k++)
            op(0,0,1,0,0,0, 11'(k * 16 + 3), 8'h00, "R9 nested call");
        for (int k = 0; k < 10; k++)
            op(0,0,0,1,0,0, 11'h0, 8'h00, "R9 circular pop");
        op(1,0,0,0,0,0, 11'h0, 8'h00, "R3 low byte after advance");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule